// File: doc/BRIEF.md
# Receive Character Matcher

This block sits beside one UART receiver and compares every completed received byte against a small table of programmable characters. Each table slot has its own enable. A hit sets a sticky status bit for that slot, and any set status bit holds the interrupt request high until the host clears it with a write-one strobe.

Three slots have fixed roles. Slot 0 holds the pause character and slot 1 holds the resume character for in-band software flow control. Slot 2 holds the station address for multidrop networks. With automatic flow handling enabled, the block drives a transmitter pause level directly. With automatic multidrop handling enabled, the block gates which received bytes go on to the receive buffer: it listens only after its own address arrives and stops at the next foreign address.

With either automatic mode off, the matching still runs and still produces status and interrupt events, so the host can take the same action in software.

Top module: `rx_char_match`

## Requirements
- R1: Slot i holds the character in char_tbl bits [8i+7:8i]. When rx_valid is high, slot_en[i] is high and rx_byte equals that character, hit_status[i] is set on the next clock.
- R2: Comparison happens only when rx_valid is high. With rx_valid low, no status bit sets, tx_pause and the listening state keep their values, and addr_hit and keep_valid stay low, whatever rx_byte and rx_addr_flag carry.
- R3: A slot whose slot_en bit is low never sets its status bit.
- R4: Status bits are sticky. stat_clr[i] high for one cycle clears hit_status[i] on the next clock. A new hit in the same cycle takes precedence over the clear.
- R5: irq is high exactly while at least one hit_status bit is set.
- R6: With flow_auto_en high, a slot 0 hit sets tx_pause on the next clock and a slot 1 hit clears it. When a single byte hits both slots, tx_pause is set.
- R7: With flow_auto_en low, tx_pause is low from the next clock on. Status bits still record hits.
- R8: With drop_auto_en high, a byte with rx_addr_flag high that hits slot 2 produces a one-cycle addr_hit pulse on the next clock.
- R9: With drop_auto_en high, a byte with rx_addr_flag high that hits slot 2 turns listening on, and any other such byte turns it off. Only bytes with rx_addr_flag low that arrive while listening are passed on keep_valid. Address bytes are never passed.
- R10: With drop_auto_en low, every valid byte is passed. keep_valid pulses on the next clock with keep_byte equal to that byte, and the listening state is cleared.
- R11: Synchronous reset clears hit_status, irq, tx_pause, addr_hit, keep_valid and the listening state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A complete received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_addr_flag | input | 1 | Received byte is marked as an address |
| char_tbl | input | 24 | Match characters, slot i at bits [8i+7:8i] |
| slot_en | input | 3 | Per-slot compare enable |
| flow_auto_en | input | 1 | Automatic pause/resume handling on |
| drop_auto_en | input | 1 | Automatic multidrop filtering on |
| stat_clr | input | 3 | Write-one-to-clear strobe per status bit |
| hit_status | output | 3 | Sticky per-slot hit flags |
| irq | output | 1 | Interrupt request |
| tx_pause | output | 1 | Transmitter pause level |
| addr_hit | output | 1 | Own-address pulse in multidrop mode |
| keep_valid | output | 1 | Byte accepted for the receive buffer |
| keep_byte | output | 8 | Accepted byte |

## Verification
Every registered result is due exactly one clock after the cycle that presents the byte. This covers the status bits, tx_pause, addr_hit, keep_valid and keep_byte. irq follows the status bits in that same cycle. The bench drives each stimulus on the falling edge and advances a reference model by one step for that cycle. It then samples every output one nanosecond after the next rising edge and compares it against the model. Directed sequences cover the same-cycle set/clear race, a byte that hits both flow slots, disabled slots, cycles with no valid byte, and the listen/stop transitions. These are followed by several thousand random cycles in which the enables and modes change every 150 cycles.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int CHAR_W    = 8;
    localparam int SLOT_CNT  = 3;
    localparam int IDX_PAUSE = 0;
    localparam int IDX_RESUME = 1;
    localparam int IDX_ADDR  = 2;

    // hits that have a dedicated automatic action
    typedef struct packed {
        logic pause;
        logic resume;
        logic addr;
    } role_hits_t;

    typedef enum logic {
        DROP_IDLE   = 1'b0,
        DROP_LISTEN = 1'b1
    } drop_state_e;

    function automatic role_hits_t pick_roles(input logic [SLOT_CNT-1:0] hv);
        role_hits_t r;
        r.pause  = hv[IDX_PAUSE];
        r.resume = hv[IDX_RESUME];
        r.addr   = hv[IDX_ADDR];
        return r;
    endfunction
endpackage

// File: rtl/rcr_slot_cmp.sv
module rcr_slot_cmp #(
    parameter int DATA_W    = 8,
    parameter int NUM_SLOTS = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rx_valid,
    input  logic [DATA_W-1:0]             rx_byte,
    input  logic [NUM_SLOTS*DATA_W-1:0]   char_tbl,
    input  logic [NUM_SLOTS-1:0]          slot_en,
    input  logic [NUM_SLOTS-1:0]          clr_w1c,
    output logic [NUM_SLOTS-1:0]          hit_now,
    output logic [NUM_SLOTS-1:0]          hit_status
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign hit_now[s] = rx_valid && slot_en[s] &&
                            (rx_byte == char_tbl[s*DATA_W +: DATA_W]);

        always_ff @(posedge clk) begin
            if (rst)
                hit_status[s] <= 1'b0;
            else if (hit_now[s])
                hit_status[s] <= 1'b1;
            else if (clr_w1c[s])
                hit_status[s] <= 1'b0;
        end
    end

    // R2
    status_set_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (|(hit_status & ~$past(hit_status))) |-> $past(rx_valid));

    // R4
    status_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (|($past(hit_status) & ~hit_status)) |-> $past(|clr_w1c));

    // R3
    disabled_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (|(hit_status & ~$past(hit_status) & ~$past(slot_en))) == 1'b0);
endmodule

// File: rtl/rcr_flow_ctl.sv
module rcr_flow_ctl
    import rcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flow_en,
    input  role_hits_t hits,
    output logic       tx_pause
);
    always_ff @(posedge clk) begin
        if (rst || !flow_en)
            tx_pause <= 1'b0;
        else if (hits.pause)
            tx_pause <= 1'b1;
        else if (hits.resume)
            tx_pause <= 1'b0;
    end

    // R7
    flow_off_no_pause_chk: assert property (@(posedge clk) disable iff (rst)
        !flow_en |=> !tx_pause);

    // R6
    pause_rise_from_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_pause) |-> $past(hits.pause));
endmodule

// File: rtl/rcr_drop_ctl.sv
module rcr_drop_ctl
    import rcr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drop_en,
    input  logic              rx_valid,
    input  logic              rx_flag,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              own_addr,
    output logic              addr_hit,
    output logic              keep_valid,
    output logic [DATA_W-1:0] keep_byte
);
    drop_state_e state_q;
    logic        addr_beat;
    logic        pass_now;

    assign addr_beat = rx_valid && rx_flag;
    assign pass_now  = rx_valid && (!drop_en || (!rx_flag && state_q == DROP_LISTEN));

    always_ff @(posedge clk) begin
        if (rst || !drop_en)
            state_q <= DROP_IDLE;
        else if (addr_beat)
            state_q <= own_addr ? DROP_LISTEN : DROP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_hit   <= 1'b0;
            keep_valid <= 1'b0;
            keep_byte  <= '0;
        end else begin
            addr_hit   <= drop_en && addr_beat && own_addr;
            keep_valid <= pass_now;
            if (rx_valid)
                keep_byte <= rx_byte;
        end
    end

    // R9
    keep_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        keep_valid |-> $past(rx_valid));

    // R9
    no_addr_byte_passed_chk: assert property (@(posedge clk) disable iff (rst)
        (keep_valid && $past(drop_en)) |-> !$past(rx_flag));

    // R8
    addr_hit_mode_chk: assert property (@(posedge clk) disable iff (rst)
        addr_hit |-> ($past(drop_en) && $past(rx_flag)));
endmodule

// File: rtl/rx_char_match.sv
module rx_char_match
    import rcr_pkg::*;
#(
    parameter int DATA_W    = CHAR_W,
    parameter int NUM_SLOTS = SLOT_CNT
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rx_valid,
    input  logic [DATA_W-1:0]           rx_byte,
    input  logic                        rx_addr_flag,
    input  logic [NUM_SLOTS*DATA_W-1:0] char_tbl,
    input  logic [NUM_SLOTS-1:0]        slot_en,
    input  logic                        flow_auto_en,
    input  logic                        drop_auto_en,
    input  logic [NUM_SLOTS-1:0]        stat_clr,
    output logic [NUM_SLOTS-1:0]        hit_status,
    output logic                        irq,
    output logic                        tx_pause,
    output logic                        addr_hit,
    output logic                        keep_valid,
    output logic [DATA_W-1:0]           keep_byte
);
    logic [NUM_SLOTS-1:0] hit_now;
    role_hits_t           roles;

    rcr_slot_cmp #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) cmp_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .char_tbl(char_tbl), .slot_en(slot_en), .clr_w1c(stat_clr),
        .hit_now(hit_now), .hit_status(hit_status)
    );

    assign roles = pick_roles(hit_now[SLOT_CNT-1:0]);
    assign irq   = |hit_status;

    rcr_flow_ctl flow_i (
        .clk(clk), .rst(rst), .flow_en(flow_auto_en),
        .hits(roles), .tx_pause(tx_pause)
    );

    rcr_drop_ctl #(.DATA_W(DATA_W)) drop_i (
        .clk(clk), .rst(rst), .drop_en(drop_auto_en), .rx_valid(rx_valid),
        .rx_flag(rx_addr_flag), .rx_byte(rx_byte), .own_addr(roles.addr),
        .addr_hit(addr_hit), .keep_valid(keep_valid), .keep_byte(keep_byte)
    );

    // R5
    irq_tracks_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_valid));
endmodule

// File: tb/rx_char_match_tb_top.sv
module rx_char_match_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_addr_flag = 1'b0;
    logic [23:0] char_tbl = '0;
    logic [2:0]  slot_en = '0;
    logic        flow_auto_en = 1'b0;
    logic        drop_auto_en = 1'b0;
    logic [2:0]  stat_clr = '0;
    logic [2:0]  hit_status;
    logic        irq, tx_pause, addr_hit, keep_valid;
    logic [7:0]  keep_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference state
    logic [2:0] m_st;
    logic       m_pause, m_listen, m_ah, m_kv;
    logic [7:0] m_kb;

    always #2 clk = ~clk;

    rx_char_match dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_addr_flag(rx_addr_flag), .char_tbl(char_tbl), .slot_en(slot_en),
        .flow_auto_en(flow_auto_en), .drop_auto_en(drop_auto_en),
        .stat_clr(stat_clr), .hit_status(hit_status), .irq(irq),
        .tx_pause(tx_pause), .addr_hit(addr_hit), .keep_valid(keep_valid),
        .keep_byte(keep_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] ref_hits(input logic v, input logic [7:0] b);
        logic [2:0] h;
        for (int s = 0; s < 3; s++)
            h[s] = v && slot_en[s] && (b == char_tbl[s*8 +: 8]);
        return h;
    endfunction

    task automatic step(input logic v, input logic [7:0] b, input logic f, input logic [2:0] clr);
        logic [2:0] h;
        @(negedge clk);
        rx_valid = v; rx_byte = b; rx_addr_flag = f; stat_clr = clr;
        h = ref_hits(v, b);
        m_st = h | (m_st & ~clr);
        if (!flow_auto_en)  m_pause = 1'b0;
        else if (h[0])      m_pause = 1'b1;
        else if (h[1])      m_pause = 1'b0;
        m_ah = drop_auto_en && v && f && h[2];
        m_kv = v && (!drop_auto_en || (!f && m_listen));
        if (v) m_kb = b;
        if (!drop_auto_en)  m_listen = 1'b0;
        else if (v && f)    m_listen = h[2];
        @(posedge clk);
        #1;
        chk("R1 R2 R3 R4 hit_status", 32'(hit_status), 32'(m_st));
        chk("R5 irq", 32'(irq), 32'(|m_st));
        chk("R6 R7 tx_pause", 32'(tx_pause), 32'(m_pause));
        chk("R8 addr_hit", 32'(addr_hit), 32'(m_ah));
        chk("R9 R10 keep_valid", 32'(keep_valid), 32'(m_kv));
        if (m_kv) chk("R10 keep_byte", 32'(keep_byte), 32'(m_kb));
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        m_st = '0; m_pause = 0; m_listen = 0; m_ah = 0; m_kv = 0; m_kb = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 hit_status", 32'(hit_status), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 tx_pause", 32'(tx_pause), 0);
        chk("R11 keep_valid", 32'(keep_valid), 0);
        chk("R11 addr_hit", 32'(addr_hit), 0);
        @(negedge clk);
        rst = 1'b0;
        char_tbl = {8'hA5, 8'h11, 8'h13};
        slot_en = 3'b111;
        flow_auto_en = 1'b1;

        // R1 R6 pause then idle cycle (R2) then resume with clear (R4)
        step(1, 8'h13, 0, 3'b000);
        step(0, 8'h11, 1, 3'b000);
        step(1, 8'h11, 0, 3'b001);
        // R4 set wins over clear
        step(1, 8'h13, 0, 3'b001);
        step(0, 8'h00, 0, 3'b111);
        // R6 same char on both flow slots
        char_tbl = {8'hA5, 8'h13, 8'h13};
        step(1, 8'h13, 0, 3'b000);
        step(0, 8'h00, 0, 3'b111);
        // R3 disabled slot
        slot_en = 3'b110;
        step(1, 8'h13, 0, 3'b000);
        // R7 flow auto off
        slot_en = 3'b111;
        char_tbl = {8'hA5, 8'h11, 8'h13};
        step(1, 8'h13, 0, 3'b000);
        flow_auto_en = 1'b0;
        step(1, 8'h13, 0, 3'b111);
        // R8 R9 multidrop listening
        drop_auto_en = 1'b1;
        step(1, 8'h40, 0, 3'b000);
        step(1, 8'hA5, 1, 3'b000);
        step(1, 8'h41, 0, 3'b000);
        step(1, 8'h42, 0, 3'b000);
        step(0, 8'h77, 1, 3'b000);
        step(1, 8'h5A, 1, 3'b000);
        step(1, 8'h43, 0, 3'b000);
        step(1, 8'hA5, 1, 3'b100);
        step(1, 8'h44, 0, 3'b000);
        // R10 multidrop off
        drop_auto_en = 1'b0;
        step(1, 8'h45, 1, 3'b000);
        step(1, 8'h46, 0, 3'b000);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] b;
            int pick;
            if (i % 150 == 0) begin
                slot_en = 3'($urandom);
                flow_auto_en = 1'($urandom);
                drop_auto_en = 1'($urandom);
                if ((i / 150) % 5 == 4)
                    char_tbl = {8'($urandom), 8'($urandom), 8'($urandom)};
            end
            pick = int'($urandom % 4);
            b = (pick < 3) ? char_tbl[pick*8 +: 8] : 8'($urandom);
            step(($urandom % 4) != 0, b, ($urandom % 3) == 0,
                 {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0});
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule